// File: doc/BRIEF.md
# Frame-Start Phase Offset Tracker

This block tracks how far the audio frame start lies from the bus start-of-frame (SOF) marker and keeps that distance as an unwrapped signed number. Each SOF brings two timer captures: the value taken at the SOF itself, which equals one frame period, and the value taken when the audio frame began. The frame-start capture is folded into a relative offset that lies near the range of plus or minus half a frame. Whenever the folded value jumps across the half-frame boundary rather than across zero, a base offset moves by one whole frame. The sum of base and relative offset is the combined offset that a rate controller downstream consumes.

Offsets count in units of 2^-FRAC_BITS samples, so one frame spans N = SAMPLES_PER_FRAME << FRAC_BITS units. When the timer runs freely, FREE_RUN is set. The captures are then rescaled into these units by dividing by the tick count per unit. A shared multi-cycle divider does this work. A start pulse seeds the tracker when a stream opens. Its relative offset is placed at the half-frame point, and the base is set from the number of audio blocks already queued.

Top module: `phase_offset_tracker`

## Requirements
- R1: After reset, rel_offset, base_offset and combined_offset are 0, and done and busy are low.
- R2: A start pulse sets rel_offset to N/2 and base_offset to (start_blocks - 2) * N on the next clock edge. It aborts any measurement in flight, so no done follows for that measurement.
- R3: The scaled frame-start value s is folded as follows: rel_offset becomes s - N when s > N/2, and s otherwise. A value of exactly N/2 stays positive.
- R4: When the new relative offset and the stored one differ in sign (a value of zero counts as non-negative), and the jump between them is larger than N/2, base_offset moves by -N if the new value is non-negative and by +N if it is negative. A jump of N/2 or less leaves the base unchanged.
- R5: When the new and the stored relative offsets have the same sign, base_offset is unchanged.
- R6: With FREE_RUN set, s = fs_cap / max(1, floor(sof_cap / N)). With FREE_RUN clear, s = fs_cap.
- R7: combined_offset equals base_offset + rel_offset, and it is updated in the same cycle as them.
- R8: A sof_valid pulse raises busy from the next cycle until a single-cycle done pulse, at which point busy is low. A sof_valid that arrives while busy is high is ignored.
- R9: rel_offset and base_offset hold their values unless done or the cycle after a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_valid | input | 1 | One-cycle pulse: captures are valid |
| sof_cap | input | CAP_W | Timer value captured at SOF (frame period) |
| fs_cap | input | CAP_W | Timer value captured at audio frame start |
| start | input | 1 | Stream start pulse |
| start_blocks | input | QUEUE_W | Audio blocks queued at stream start |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse: offsets updated |
| rel_offset | output | 32 | Folded relative offset (signed) |
| base_offset | output | 32 | Accumulated whole-frame base (signed) |
| combined_offset | output | 32 | base_offset + rel_offset (signed) |

## Verification
The bench targets the fold boundary at exactly N/2. A design that used >= there would report -N/2 instead of +N/2. It also checks jumps of exactly N/2 against jumps just above it, and a crossing near zero against a crossing near the outer bound. A tracker that confused these would add or drop a whole frame of base offset and leave the combined offset off by N. An SOF capture below one frame is applied so that the divisor clamps to 1; without the clamp, a zero divisor would give a garbage quotient. Further cases cover a second SOF arriving while busy, which must not change the result, and a start pulse during a measurement, which must cancel the pending done. Seeds with zero queued blocks are included and must give a negative base.

// File: rtl/phtrk_pkg.sv
package phtrk_pkg;

    localparam int PH_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIV_CLK = 2'd1,
        ST_DIV_FS  = 2'd2,
        ST_APPLY   = 2'd3
    } phtrk_state_e;

    typedef struct packed {
        logic signed [PH_W-1:0] rel_new;
        logic signed [PH_W-1:0] base_step;
    } phtrk_upd_t;

    function automatic logic is_neg(input logic signed [PH_W-1:0] v);
        return v[PH_W-1];
    endfunction

endpackage

// File: rtl/phtrk_divider.sv
module phtrk_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         done
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [W:0]   shifted;
    logic [W+1:0] diff;

    assign shifted  = {rem_q[W-1:0], quo_q[W-1]};
    assign diff     = {1'b0, shifted} - {2'b00, divisor};
    assign quotient = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (diff[W+1]) begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end else begin
                    rem_q <= diff[W:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/phtrk_unwrap.sv
module phtrk_unwrap import phtrk_pkg::*; #(
    parameter int CAP_W       = 32,
    parameter int FRAME_UNITS = 1536
) (
    input  logic [CAP_W-1:0]       scaled,
    input  logic signed [PH_W-1:0] rel_old,
    output phtrk_upd_t             upd
);
    localparam logic signed [PH_W-1:0] FRAME_S = PH_W'(FRAME_UNITS);
    localparam logic signed [PH_W:0]   HALF_X  = (PH_W+1)'(FRAME_UNITS / 2);

    logic [PH_W-1:0]        scaled_w;
    logic signed [PH_W-1:0] rel_new;
    logic                   old_neg;
    logic                   new_neg;
    logic signed [PH_W:0]   old_x;
    logic signed [PH_W:0]   new_x;
    logic signed [PH_W:0]   jump;

    assign scaled_w = PH_W'(scaled);

    always_comb begin
        if (scaled_w > PH_W'(FRAME_UNITS / 2))
            rel_new = $signed(scaled_w) - FRAME_S;
        else
            rel_new = $signed(scaled_w);
    end

    assign old_neg = is_neg(rel_old);
    assign new_neg = is_neg(rel_new);
    assign old_x   = {rel_old[PH_W-1], rel_old};
    assign new_x   = {rel_new[PH_W-1], rel_new};
    assign jump    = new_neg ? (old_x - new_x) : (new_x - old_x);

    always_comb begin
        upd.rel_new   = rel_new;
        upd.base_step = '0;
        if ((old_neg != new_neg) && (jump > HALF_X))
            upd.base_step = new_neg ? FRAME_S : -FRAME_S;
    end
endmodule

// File: rtl/phase_offset_tracker.sv
module phase_offset_tracker import phtrk_pkg::*; #(
    parameter int CAP_W             = 32,
    parameter int SAMPLES_PER_FRAME = 48,
    parameter int FRAC_BITS         = 5,
    parameter int QUEUE_W           = 4,
    parameter bit FREE_RUN          = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sof_valid,
    input  logic [CAP_W-1:0]       sof_cap,
    input  logic [CAP_W-1:0]       fs_cap,
    input  logic                   start,
    input  logic [QUEUE_W-1:0]     start_blocks,
    output logic                   busy,
    output logic                   done,
    output logic signed [PH_W-1:0] rel_offset,
    output logic signed [PH_W-1:0] base_offset,
    output logic signed [PH_W-1:0] combined_offset
);
    localparam int FRAME_UNITS = SAMPLES_PER_FRAME << FRAC_BITS;
    localparam logic signed [PH_W-1:0] FRAME_S = PH_W'(FRAME_UNITS);
    localparam logic signed [PH_W-1:0] HALF_S  = PH_W'(FRAME_UNITS / 2);

    phtrk_state_e state_q;
    logic [CAP_W-1:0] fs_q;
    logic [CAP_W-1:0] scaled_q;
    logic [CAP_W-1:0] div_a_q;
    logic [CAP_W-1:0] div_b_q;
    logic             div_go_q;
    logic [CAP_W-1:0] div_quo;
    logic             div_done;
    logic [CAP_W-1:0] ticks_per_unit;
    logic             div_ready;

    logic signed [PH_W-1:0] blk_s;
    logic signed [PH_W-1:0] seed_base;
    logic signed [PH_W-1:0] next_base;
    phtrk_upd_t             upd;

    phtrk_divider #(.W(CAP_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go_q),
        .dividend (div_a_q),
        .divisor  (div_b_q),
        .quotient (div_quo),
        .done     (div_done)
    );

    phtrk_unwrap #(.CAP_W(CAP_W), .FRAME_UNITS(FRAME_UNITS)) unwrap_i (
        .scaled  (scaled_q),
        .rel_old (rel_offset),
        .upd     (upd)
    );

    assign ticks_per_unit = (div_quo == '0) ? CAP_W'(1) : div_quo;
    // A done seen while a new go is still pending belongs to an aborted run.
    assign div_ready = div_done && !div_go_q;
    assign blk_s     = PH_W'(start_blocks) - PH_W'(2);
    assign seed_base = blk_s * FRAME_S;
    assign next_base = base_offset + upd.base_step;
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= ST_IDLE;
            fs_q            <= '0;
            scaled_q        <= '0;
            div_a_q         <= '0;
            div_b_q         <= '0;
            div_go_q        <= 1'b0;
            done            <= 1'b0;
            rel_offset      <= '0;
            base_offset     <= '0;
            combined_offset <= '0;
        end else begin
            div_go_q <= 1'b0;
            done     <= 1'b0;
            if (start) begin
                state_q         <= ST_IDLE;
                rel_offset      <= HALF_S;
                base_offset     <= seed_base;
                combined_offset <= seed_base + HALF_S;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (sof_valid) begin
                            fs_q <= fs_cap;
                            if (FREE_RUN) begin
                                div_a_q  <= sof_cap;
                                div_b_q  <= CAP_W'(FRAME_UNITS);
                                div_go_q <= 1'b1;
                                state_q  <= ST_DIV_CLK;
                            end else begin
                                scaled_q <= fs_cap;
                                state_q  <= ST_APPLY;
                            end
                        end
                    end
                    ST_DIV_CLK: begin
                        if (div_ready) begin
                            div_a_q  <= fs_q;
                            div_b_q  <= ticks_per_unit;
                            div_go_q <= 1'b1;
                            state_q  <= ST_DIV_FS;
                        end
                    end
                    ST_DIV_FS: begin
                        if (div_ready) begin
                            scaled_q <= div_quo;
                            state_q  <= ST_APPLY;
                        end
                    end
                    ST_APPLY: begin
                        rel_offset      <= upd.rel_new;
                        base_offset     <= next_base;
                        combined_offset <= next_base + upd.rel_new;
                        done            <= 1'b1;
                        state_q         <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/phtrk_checker.sv
module phtrk_checker import phtrk_pkg::*; #(
    parameter int FRAME_UNITS = 1536
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic signed [PH_W-1:0] rel_offset,
    input logic signed [PH_W-1:0] base_offset,
    input logic signed [PH_W-1:0] combined_offset
);
    localparam logic signed [PH_W-1:0] FR = PH_W'(FRAME_UNITS);
    localparam logic signed [PH_W-1:0] HF = PH_W'(FRAME_UNITS / 2);

    AST_BASE_WHOLE_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> (base_offset == $past(base_offset) || base_offset == $past(base_offset) + FR
                  || base_offset == $past(base_offset) - FR)); // R4

    AST_START_SEEDS_REL: assert property (@(posedge clk) disable iff (rst)
        start |=> (rel_offset == HF && !done)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_OFFSETS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(start)) |-> ($stable(rel_offset) && $stable(base_offset))); // R9

    AST_COMBINED_SUM: assert property (@(posedge clk) disable iff (rst)
        done |-> (combined_offset == base_offset + rel_offset)); // R7
endmodule

bind phase_offset_tracker phtrk_checker #(.FRAME_UNITS(FRAME_UNITS)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .busy            (busy),
    .done            (done),
    .rel_offset      (rel_offset),
    .base_offset     (base_offset),
    .combined_offset (combined_offset)
);

// File: tb/phase_offset_tracker_tb_top.sv
module phase_offset_tracker_tb_top;
    localparam int CAP_W = 32;
    localparam int SPF   = 48;
    localparam int FB    = 5;
    localparam int QW    = 4;
    localparam longint N = longint'(SPF) << FB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof_valid = 1'b0;
    logic [CAP_W-1:0] sof_cap = '0;
    logic [CAP_W-1:0] fs_cap = '0;
    logic start = 1'b0;
    logic [QW-1:0] start_blocks = '0;
    logic busy, done;
    logic signed [31:0] rel_offset, base_offset, combined_offset;

    int checks = 0;
    int errors = 0;
    longint m_rel = 0;
    longint m_base = 0;

    always #10 clk = ~clk;

    phase_offset_tracker #(.CAP_W(CAP_W), .SAMPLES_PER_FRAME(SPF), .FRAC_BITS(FB),
                           .QUEUE_W(QW), .FREE_RUN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .sof_valid(sof_valid), .sof_cap(sof_cap), .fs_cap(fs_cap),
        .start(start), .start_blocks(start_blocks), .busy(busy), .done(done),
        .rel_offset(rel_offset), .base_offset(base_offset), .combined_offset(combined_offset)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_offsets(input string req);
        check({req, " rel"}, longint'(rel_offset), m_rel);
        check({req, " base"}, longint'(base_offset), m_base);
        check({req, " R7 combined"}, longint'(combined_offset), m_rel + m_base);
    endtask

    function automatic longint scale(input longint s, input longint f);
        longint k = s / N;
        if (k < 1) k = 1;
        return f / k;
    endfunction

    function automatic void model_update(input longint s);
        longint nr = (s > N / 2) ? s - N : s;
        longint jmp;
        if ((m_rel >= 0) != (nr >= 0)) begin
            jmp = (nr >= 0) ? nr - m_rel : m_rel - nr;
            if (jmp > N / 2) m_base += (nr >= 0) ? -N : N;
        end
        m_rel = nr;
    endfunction

    task automatic do_start(input int blocks, input string req);
        @(negedge clk);
        start = 1'b1;
        start_blocks = QW'(blocks);
        @(negedge clk);
        start = 1'b0;
        m_rel = N / 2;
        m_base = (longint'(blocks) - 2) * N;
        check_offsets(req);
    endtask

    task automatic measure(input longint s, input longint f, input bit inject, input string req);
        int cyc = 0;
        @(negedge clk);
        sof_cap = CAP_W'(s);
        fs_cap = CAP_W'(f);
        sof_valid = 1'b1;
        @(negedge clk);
        sof_valid = 1'b0;
        check("R8 busy after sof", longint'(busy), 1);
        while (!done && cyc < 400) begin
            if (inject && cyc == 3) begin
                sof_cap = CAP_W'(N * 3);
                fs_cap = CAP_W'(N * 2);
                sof_valid = 1'b1;
            end else begin
                sof_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        sof_valid = 1'b0;
        check("R8 done seen", longint'(done), 1);
        check("R8 busy low at done", longint'(busy), 0);
        model_update(scale(s, f));
        check_offsets(req);
        @(negedge clk);
        check("R8 done single cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rel", longint'(rel_offset), 0);
        check("R1 base", longint'(base_offset), 0);
        check("R1 combined", longint'(combined_offset), 0);
        check("R1 done", longint'(done), 0);
        check("R1 busy", longint'(busy), 0);

        do_start(2, "R2 seed two blocks");
        measure(N * 10, 1000, 1'b0, "R3 R5 R6 direct small");
        measure(N * 10, 7690, 1'b0, "R3 R4 fold outer crossing +N");
        measure(N * 10, 7680, 1'b0, "R3 R4 half boundary -N");
        measure(N * 4, 20, 1'b0, "R5 R6 positive small");
        measure(N * 4, 6120, 1'b0, "R4 zero crossing no base step");
        measure(N * 2, 3072 - 768, 1'b0, "R4 jump check");
        do_start(2, "R2 reseed");
        measure(N, 384, 1'b0, "R5 set 384");
        measure(N, 1152, 1'b0, "R4 jump exactly N/2 no step");
        measure(1000, 600, 1'b0, "R6 sof below one frame clamp");
        measure(N * 7, 2100, 1'b1, "R8 sof while busy ignored");

        // R9 hold with no stimulus
        repeat (10) @(negedge clk);
        check_offsets("R9 hold idle");

        // R2 start aborts a measurement in flight
        @(negedge clk);
        sof_cap = CAP_W'(N * 5);
        fs_cap = CAP_W'(100);
        sof_valid = 1'b1;
        @(negedge clk);
        sof_valid = 1'b0;
        repeat (4) @(negedge clk);
        do_start(5, "R2 abort seed");
        begin
            int seen = 0;
            for (int i = 0; i < 120; i++) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R2 no done after abort", longint'(seen), 0);
            check("R2 idle after abort", longint'(busy), 0);
        end
        check_offsets("R2 R9 offsets after abort");

        do_start(0, "R2 zero blocks negative base");

        for (int i = 0; i < 200; i++) begin
            longint s = longint'($urandom_range(32'(N) * 40, 32'(N)));
            longint f = longint'($urandom_range(32'(s - 1), 0));
            measure(s, f, 1'b0, "R3 R4 R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule